// File: doc/BRIEF.md
# Table-Driven Sense State Machine

This block steps through a small state table held in a local byte memory. The current state is always the last byte fetched from that table. Each fetched byte lands in an 8-bit output latch, and a one-cycle valid pulse marks the update. Downstream logic uses the latch bits as control outputs. The next table slot is formed from selected bits of the current byte together with two live sense inputs, so each row of the table acts as a small branch on the sensed condition.

A stop strobe from an external timing sequencer marks the end of each measurement cycle. A byte whose top bit is clear holds its state until that strobe falls. A byte whose top bit is set chains to the next row on the next clock, which lets several table rows run back to back inside one measurement cycle. Two index-extension enables decide whether bits 6 and 7 of the current byte widen the index. The table base address is an input. The table is loaded through a simple write port.

Top module: `sense_tbl_fsm`

## Requirements
- R1: While `en` is 0, `state_out` reads 0x00, `state_valid` stays 0 and the machine returns to its start phase.
- R2: On the first enabled cycle the latch loads the byte at `base_addr + {s2,s1}` (for example s2=1, s1=0 selects base+2), and this load does not wait for the stop strobe.
- R3: The 8-bit next index is {Q7', Q6', Q5, Q4, Q3, Q0, s2, s1}, bit 7 first, where Qn are bits of the current latch; Q1 and Q2 have no effect on it.
- R4: Q6' equals Q6 only when `q6_en` is 1, and Q7' equals Q7 only when both `q6_en` and `q7_en` are 1; a position that is not enabled contributes 0.
- R5: The next byte is read from `base_addr + index`, modulo 2^ADDR_W.
- R6: When Q7 of the current latch is 0, the state advances only on a falling edge of `stop_in`. The new byte appears on the third rising clock edge after the falling level is first sampled (two synchronizer stages plus edge detection).
- R7: When Q7 of the current latch is 1, the next byte is loaded on the very next clock, whatever `q6_en` and `q7_en` are.
- R8: `state_valid` is high for exactly one cycle per latch update and is low otherwise.
- R9: A rising edge of `stop_in` causes no state change.
- R10: A write with `cfg_we` stores `cfg_data` at `cfg_addr`, and later fetches from that address return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; 0 holds the machine cleared |
| s1 | input | 1 | Sense input, index bit 0 |
| s2 | input | 1 | Sense input, index bit 1 |
| stop_in | input | 1 | End-of-sequence strobe from the timing sequencer (asynchronous, slow) |
| q6_en | input | 1 | Include bit 6 of the state in the index |
| q7_en | input | 1 | Include bit 7 of the state in the index (only with q6_en) |
| base_addr | input | ADDR_W | Table base address |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | ADDR_W | Table write address |
| cfg_data | input | 8 | Table write data |
| state_out | output | 8 | Output latch holding the current state |
| state_valid | output | 1 | One-cycle pulse on each latch update |

## Verification
The assertions check on every cycle that the disabled state is cleared and that the first enabled cycle always loads. They also check that a byte with the top bit set always chains on the next edge, and that a byte with the top bit clear holds without a detected falling edge. The edge detector's pulse lasts one cycle, and a table write takes effect on the following cycle. Which byte is fetched can only be shown by the bench's scenarios: the index layout, the masking of bits 6 and 7 under each enable combination, the address wrap, the indifference to bits 1 and 2, the three-edge latency after a falling strobe, and the absence of any transition on a rising strobe.

// File: rtl/sfsm_pkg.sv
package sfsm_pkg;
   localparam int ENTRY_W = 8;
   localparam int IDX_W   = 8;
   localparam int OFF_W   = 2;

   typedef logic [ENTRY_W-1:0] entry_t;
   typedef logic [IDX_W-1:0]   index_t;

   typedef enum logic {
      PH_OFF = 1'b0,
      PH_RUN = 1'b1
   } phase_t;
endpackage

// File: rtl/sfsm_stop_sync.sv
module sfsm_stop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_in,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfsm_stop_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= stop_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign fall_o = last_q & ~sync_q[STAGES-1];

   // R6: a detected falling edge lasts one cycle only
   p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/sfsm_table.sv
module sfsm_table #(
   parameter int ADDR_W  = 8,
   parameter int ENTRY_W = 8
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [ENTRY_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W > 12) begin : g_bad_depth
         $error("sfsm_table: ADDR_W too large for a local table");
      end
   endgenerate

   logic [ENTRY_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];

   // R10: a write is visible at its address on the following cycle
   p_write_lands_r10: assert property (@(posedge clk)
      wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/sfsm_index.sv
module sfsm_index
   import sfsm_pkg::*;
(
   input  logic [7:3] q_hi,
   input  logic       q0,
   input  logic       s1,
   input  logic       s2,
   input  logic       q6_en,
   input  logic       q7_en,
   output index_t     idx
);
   logic ext7;
   logic ext6;

   always_comb begin
      ext6 = q6_en & q_hi[6];
      ext7 = q6_en & q7_en & q_hi[7];
      idx  = {ext7, ext6, q_hi[5], q_hi[4], q_hi[3], q0, s2, s1};
   end
endmodule

// File: rtl/sense_tbl_fsm.sv
module sense_tbl_fsm
   import sfsm_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              s1,
   input  logic              s2,
   input  logic              stop_in,
   input  logic              q6_en,
   input  logic              q7_en,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [7:0]        cfg_data,
   output logic [7:0]        state_out,
   output logic              state_valid
);
   generate
      if (ADDR_W < IDX_W) begin : g_bad_aw
         $error("sense_tbl_fsm: ADDR_W must cover the 8-bit index");
      end
   endgenerate

   phase_t              phase_q;
   entry_t              latch_q;
   logic                valid_q;
   logic                stop_fall;
   index_t              nxt_idx;
   logic [OFF_W-1:0]    start_off;
   logic [ADDR_W-1:0]   rd_addr;
   entry_t              rd_data;
   logic                take;

   sfsm_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .stop_in (stop_in),
      .fall_o  (stop_fall)
   );

   sfsm_index u_index (
      .q_hi  (latch_q[7:3]),
      .q0    (latch_q[0]),
      .s1    (s1),
      .s2    (s2),
      .q6_en (q6_en),
      .q7_en (q7_en),
      .idx   (nxt_idx)
   );

   sfsm_table #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_table (
      .clk     (clk),
      .wr_en   (cfg_we),
      .wr_addr (cfg_addr),
      .wr_data (cfg_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign start_off = {s2, s1};

   always_comb begin
      if (phase_q == PH_OFF) rd_addr = base_addr + ADDR_W'(start_off);
      else                   rd_addr = base_addr + ADDR_W'(nxt_idx);
   end

   assign take = (phase_q == PH_OFF) || latch_q[7] || stop_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         latch_q <= '0;
         valid_q <= 1'b0;
      end else if (!en) begin
         phase_q <= PH_OFF;
         latch_q <= '0;
         valid_q <= 1'b0;
      end else begin
         phase_q <= PH_RUN;
         valid_q <= take;
         if (take) latch_q <= rd_data;
      end
   end

   assign state_out   = latch_q;
   assign state_valid = valid_q;

   // R1: disabled cycle clears the latch and the valid flag
   p_off_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state_out == 8'h00 && !state_valid && phase_q == PH_OFF));

   // R2: first enabled cycle always loads
   p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase_q == PH_OFF) |=> (state_valid && phase_q == PH_RUN));

   // R7: a set top bit chains on the next edge
   p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase_q == PH_RUN && state_out[7]) |=> state_valid);

   // R6: a clear top bit holds without a detected falling edge
   p_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase_q == PH_RUN && !state_out[7] && !stop_fall)
         |=> (!state_valid && $stable(state_out)));
endmodule

// File: tb/tb_sense_tbl_fsm.sv
module tb_sense_tbl_fsm;
   logic       clk = 1'b0;
   logic       rst_n, en, s1, s2, stop_in, q6_en, q7_en, cfg_we;
   logic [7:0] base_addr, cfg_addr, cfg_data, state_out;
   logic       state_valid;

   always #4 clk = ~clk;

   sense_tbl_fsm dut (
      .clk(clk), .rst_n(rst_n), .en(en), .s1(s1), .s2(s2), .stop_in(stop_in),
      .q6_en(q6_en), .q7_en(q7_en), .base_addr(base_addr), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .state_out(state_out), .state_valid(state_valid)
   );

   logic [7:0] ref_mem [256];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   int         errors = 0;
   int         checks = 0;
   int         vcount = 0;
   logic [7:0] cur = 8'h00;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] idx_of(input logic [7:0] e, input logic [1:0] s,
                                         input logic e6, input logic e7);
      return {e[7] & e6 & e7, e[6] & e6, e[5], e[4], e[3], e[0], s};
   endfunction

   // push the byte at addr and every byte it chains to
   task automatic expect_from(input logic [7:0] addr, input string tag);
      logic [7:0] a = addr;
      exp_q.push_back(ref_mem[a]);
      tag_q.push_back(tag);
      cur = ref_mem[a];
      for (int n = 0; n < 16 && cur[7]; n++) begin
         a = base_addr + idx_of(cur, {s2, s1}, q6_en, q7_en);
         exp_q.push_back(ref_mem[a]);
         tag_q.push_back("R7");
         cur = ref_mem[a];
      end
   endtask

   // monitor: pop and compare on each valid pulse
   always @(posedge clk) begin
      #2;
      if (rst_n && state_valid) begin
         vcount++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected valid", state_out, 0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(state_out == e, t, "latched byte", state_out, e);
         end
      end
      if (rst_n && !en)
         check(state_out == 8'h00 && !state_valid, "R1", "disabled output",
               {state_valid, state_out}, 0);
   end

   task automatic write_tbl(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
      ref_mem[a] = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic start(input logic [7:0] b, input logic [1:0] s,
                        input logic e6, input logic e7);
      int c0;
      int want;
      @(negedge clk);
      base_addr = b; {s2, s1} = s; q6_en = e6; q7_en = e7;
      c0 = vcount;
      want = ref_mem[8'(b + 8'(s))][7] ? 2 : 1;
      expect_from(8'(b + 8'(s)), "R2");
      en = 1'b1;
      @(posedge clk); @(posedge clk); #3;
      check(vcount == c0 + want, "R7", "loads after two edges", vcount - c0, want);
   endtask

   task automatic stop_cycle(input logic [1:0] s, input string tag);
      int c0;
      @(negedge clk);
      {s2, s1} = s;
      stop_in = 1'b1;
      c0 = vcount;
      repeat (12) @(negedge clk);
      check(vcount == c0, "R9", "rising strobe ignored", vcount - c0, 0);
      expect_from(8'(base_addr + idx_of(cur, s, q6_en, q7_en)), tag);
      stop_in = 1'b0;
      @(posedge clk); @(posedge clk); #3;
      check(vcount == c0, "R6", "no update before third edge", vcount - c0, 0);
      @(posedge clk); #3;
      check(vcount == c0 + 1, "R6", "update on third edge", vcount - c0, 1);
      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R8", "all expected updates seen", exp_q.size(), 0);
      check(vcount - c0 >= 1, "R6", "held until next strobe", vcount - c0, 1);
   endtask

   task automatic stop_all();
      @(negedge clk);
      en = 1'b0;
      repeat (4) @(negedge clk);
      check(state_out == 8'h00, "R1", "cleared after disable", state_out, 0);
   endtask

   initial begin
      #(8 * 150000);
      check(1'b0, "R8", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; en = 1'b0; s1 = 1'b0; s2 = 1'b0; stop_in = 1'b0;
      q6_en = 1'b0; q7_en = 1'b0; cfg_we = 1'b0;
      base_addr = 8'h00; cfg_addr = 8'h00; cfg_data = 8'h00;
      repeat (3) @(negedge clk);
      check(state_out == 8'h00 && !state_valid, "R1", "reset state",
            {state_valid, state_out}, 0);
      rst_n = 1'b1;

      // table load: ordinary rows have the top bit clear
      for (int i = 0; i < 256; i++) write_tbl(8'(i), 8'((i * 29 + 7) & 8'h7F));
      write_tbl(8'h22, 8'hD9);   // chains; R10 planted row
      write_tbl(8'h21, 8'h92);   // chains; bits 1 and 4 set

      // scenario A: no index extension
      start(8'h20, 2'b10, 1'b0, 1'b0);
      stop_cycle(2'b01, "R3");
      stop_cycle(2'b11, "R5");
      stop_cycle(2'b00, "R3");
      stop_all();

      // scenario B: bit 6 extension on
      start(8'h20, 2'b10, 1'b1, 1'b0);
      stop_cycle(2'b10, "R4");
      stop_cycle(2'b01, "R4");
      stop_all();

      // scenario C: bit 7 enable alone has no effect
      start(8'h20, 2'b01, 1'b0, 1'b1);
      stop_cycle(2'b11, "R4");
      stop_all();

      // scenario D: full extension with address wrap
      write_tbl(8'h82, 8'hD9);
      write_tbl(8'hDE, 8'hC5);
      start(8'h80, 2'b10, 1'b1, 1'b1);
      stop_cycle(2'b11, "R5");
      stop_cycle(2'b10, "R10");
      stop_all();

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R8", "queue drained", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule